// File: doc/BRIEF.md
# Hot-Plug Slot Interrupt Event Logic

This block monitors the status lines of one to four hot-plug slots and signals an interrupt when an enabled slot event occurs. Each slot has seven watched inputs: the bus-isolation switch output, power-good, power-fault, two mechanical-detect lines and two card-present lines. Every input first passes through a synchronizer. Its edges are then turned into single-cycle event pulses. Power-fault produces an event only when it asserts, which is the 0-to-1 transition because the input is active high. Every other input produces an event on a change in either direction.

Each slot has two byte-wide registers on a simple byte-addressed interface: an event-enable register and a sticky event-status register. Both use the same bit layout. An event is recorded in status whether or not it is enabled. Software clears status bits by writing ones to them. The shared interrupt line is open-drain. It is modelled as an active-low drive enable, and it is pulled low while any slot holds a status bit whose enable bit is also set.

Top module: `hp_slot_irq`

## Requirements
- R1: After reset every enable and status register reads 00h and `irq_drive_n_o` is 1 (line released).
- R2: Slot s places its enable register at byte offset 8*s+7 and its status register at 8*s+6. A read of any other offset returns 00h, and a write to any other offset changes no register.
- R3: Bit 7 of both registers is reserved. It always reads 0, and writing 1 to it has no effect.
- R4: Bits 6, 5, 3, 2, 1 and 0 record an event on any level change of bus-isolation, power-good, mechanical-detect 1, mechanical-detect 0, card-present 2 and card-present 1, respectively. An input driven between clock edges is reflected in status right after the third rising edge.
- R5: Bit 4 records an event only when power-fault goes from 0 to 1. A 1-to-0 change records nothing.
- R6: Status captures an event whether or not its enable bit is set. A status bit whose enable bit is clear does not pull the interrupt line.
- R7: Status bits are sticky and are cleared by writing 1. Writing 0 leaves a bit unchanged. If an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: `irq_drive_n_o` is 0 exactly while some slot has (status AND enable) nonzero. It returns to 1 in the cycle after the write that clears the last such bit.
- R9: Input levels held steady through reset produce no events once reset is released.
- R10: An event on one slot sets status only in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_iso_i | input | NUM_SLOTS | Bus-isolation switch output, one bit per slot |
| pwr_good_i | input | NUM_SLOTS | Power-good input per slot |
| pwr_fault_i | input | NUM_SLOTS | Power-fault input per slot, active high |
| mdet1_i | input | NUM_SLOTS | Mechanical-detect 1 per slot |
| mdet0_i | input | NUM_SLOTS | Mechanical-detect 0 per slot |
| cpres2_i | input | NUM_SLOTS | Card-present 2 per slot |
| cpres1_i | input | NUM_SLOTS | Card-present 1 per slot |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_we_i | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| irq_drive_n_o | output | 1 | Open-drain interrupt drive enable, active low |

## Verification
Some properties are checked on every cycle. Status never drops a bit unless a write-one clear addressed it. Every event pulse lands in status. Enable registers move only on their own write strobe. Power-fault never produces two event pulses in a row. The interrupt is never driven while all enables are zero. Other behaviours can only be shown by the bench's scenarios: the three-edge latency from pin to status, the direction sensitivity of each source, the address map and the unmapped holes, the event-beats-clear collision, and the one-cycle release of the interrupt after the final clear.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;

   localparam int EVT_W     = 7;
   localparam int REG_W     = 8;
   localparam int STRIDE_LG = 3;

   // bit positions shared by enable and status registers
   localparam int B_BUSISO = 6;
   localparam int B_PGOOD  = 5;
   localparam int B_PFAULT = 4;
   localparam int B_MDET1  = 3;
   localparam int B_MDET0  = 2;
   localparam int B_CPRES2 = 1;
   localparam int B_CPRES1 = 0;

   // offsets within a slot's 8-byte window
   localparam logic [STRIDE_LG-1:0] OFS_EN = 3'd7;
   localparam logic [STRIDE_LG-1:0] OFS_ST = 3'd6;

   // sources that fire on assertion only
   localparam logic [EVT_W-1:0] RISE_ONLY_MASK = 7'b001_0000;

   typedef logic [EVT_W-1:0] evt_vec_t;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EN   = 2'd1,
      SEL_ST   = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/hp_sync_edge.sv
module hp_sync_edge #(
   parameter int                 W         = 7,
   parameter int                 STAGES    = 2,
   parameter logic [W-1:0]       RISE_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] evt_o
);

   localparam int PRIME_CNT = STAGES + 1;
   localparam int CNT_W     = $clog2(PRIME_CNT + 1);

   if (STAGES < 2) begin : g_bad_stages
      $error("hp_sync_edge: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hp_sync_edge: W must be positive");
   end

   logic [W-1:0]     pipe_q [STAGES];
   logic [W-1:0]     prev_q;
   logic [W-1:0]     cur;
   logic [W-1:0]     raw_evt;
   logic [CNT_W-1:0] cnt_q;
   logic             primed;

   assign cur    = pipe_q[STAGES-1];
   assign primed = (cnt_q == CNT_W'(PRIME_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
         prev_q <= '0;
      end else begin
         pipe_q[0] <= lvl_i;
         for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
         prev_q <= cur;
      end
   end

   // hold off events until the pipeline reflects real pin levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!primed) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (RISE_MASK[b]) begin : g_rise
         assign raw_evt[b] = cur[b] & ~prev_q[b];

         // R5: an assertion-only source cannot pulse on consecutive cycles
         p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(evt_o[b]) |-> !evt_o[b]);
      end else begin : g_any
         assign raw_evt[b] = cur[b] ^ prev_q[b];
      end
   end

   assign evt_o = primed ? raw_evt : '0;

endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         en_we_i,
   input  logic         st_we_i,
   input  logic [7:0]   wdata_i,
   output logic [W-1:0] en_o,
   output logic [W-1:0] st_o,
   output logic         pend_o
);

   if (W > 7) begin : g_bad_w
      $error("hp_slot_regs: W must leave bit 7 reserved");
   end

   logic [W-1:0] clr_mask;

   assign clr_mask = st_we_i ? wdata_i[W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o <= '0;
      end else if (en_we_i) begin
         en_o <= wdata_i[W-1:0];
      end
   end

   // a new event wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_o <= '0;
      end else begin
         st_o <= (st_o & ~clr_mask) | evt_i;
      end
   end

   assign pend_o = |(st_o & en_o);

   // R7: a status bit only falls when a write-one clear addressed it
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(st_o) & ~$past(st_we_i ? wdata_i[W-1:0] : {W{1'b0}}) & ~st_o) == '0));

   // R7: every event pulse is visible in status one edge later
   p_evt_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt_i) & ~st_o) == '0));

   // R2: enable only moves on its own write strobe
   p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_we_i) |-> $stable(en_o));

endmodule

// File: rtl/hp_reg_decode.sv
module hp_reg_decode
   import hp_irq_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int SLOT_W    = 2,
   parameter int ADDR_W    = 5
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [SLOT_W-1:0] slot_o,
   output reg_sel_e          sel_o
);

   if (ADDR_W != SLOT_W + STRIDE_LG) begin : g_bad_addr
      $error("hp_reg_decode: ADDR_W must equal SLOT_W plus the stride width");
   end

   logic [STRIDE_LG-1:0] ofs;
   logic                 in_range;

   assign slot_o   = addr_i[ADDR_W-1:STRIDE_LG];
   assign ofs      = addr_i[STRIDE_LG-1:0];
   assign in_range = (int'(slot_o) < NUM_SLOTS);

   always_comb begin
      sel_o = SEL_NONE;
      if (in_range) begin
         if (ofs == OFS_EN)      sel_o = SEL_EN;
         else if (ofs == OFS_ST) sel_o = SEL_ST;
      end
   end

endmodule

// File: rtl/hp_slot_irq.sv
module hp_slot_irq
   import hp_irq_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   parameter int ADDR_W      = SLOT_W + 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] bus_iso_i,
   input  logic [NUM_SLOTS-1:0] pwr_good_i,
   input  logic [NUM_SLOTS-1:0] pwr_fault_i,
   input  logic [NUM_SLOTS-1:0] mdet1_i,
   input  logic [NUM_SLOTS-1:0] mdet0_i,
   input  logic [NUM_SLOTS-1:0] cpres2_i,
   input  logic [NUM_SLOTS-1:0] cpres1_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic                 reg_we_i,
   input  logic [REG_W-1:0]     reg_wdata_i,
   output logic [REG_W-1:0]     reg_rdata_o,
   output logic                 irq_drive_n_o
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
      $error("hp_slot_irq: NUM_SLOTS must be 1 to 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hp_slot_irq: SYNC_STAGES must be at least 2");
   end

   evt_vec_t              slot_lvl [NUM_SLOTS];
   evt_vec_t              slot_evt [NUM_SLOTS];
   evt_vec_t              en_q     [NUM_SLOTS];
   evt_vec_t              st_q     [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]  pend;
   logic [NUM_SLOTS-1:0]  en_we;
   logic [NUM_SLOTS-1:0]  st_we;
   logic [SLOT_W-1:0]     dec_slot;
   reg_sel_e              dec_sel;
   evt_vec_t              en_or;

   hp_reg_decode #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .addr_i (reg_addr_i),
      .slot_o (dec_slot),
      .sel_o  (dec_sel)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_lvl[s] = {bus_iso_i[s], pwr_good_i[s], pwr_fault_i[s],
                            mdet1_i[s], mdet0_i[s], cpres2_i[s], cpres1_i[s]};

      assign en_we[s] = reg_we_i && (dec_sel == SEL_EN) && (dec_slot == SLOT_W'(s));
      assign st_we[s] = reg_we_i && (dec_sel == SEL_ST) && (dec_slot == SLOT_W'(s));

      hp_sync_edge #(
         .W         (EVT_W),
         .STAGES    (SYNC_STAGES),
         .RISE_MASK (RISE_ONLY_MASK)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl_i (slot_lvl[s]),
         .evt_o (slot_evt[s])
      );

      hp_slot_regs #(
         .W (EVT_W)
      ) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_i   (slot_evt[s]),
         .en_we_i (en_we[s]),
         .st_we_i (st_we[s]),
         .wdata_i (reg_wdata_i),
         .en_o    (en_q[s]),
         .st_o    (st_q[s]),
         .pend_o  (pend[s])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (dec_slot == SLOT_W'(s)) begin
            case (dec_sel)
               SEL_EN:  reg_rdata_o = {1'b0, en_q[s]};
               SEL_ST:  reg_rdata_o = {1'b0, st_q[s]};
               default: reg_rdata_o = '0;
            endcase
         end
      end
   end

   always_comb begin
      en_or = '0;
      for (int s = 0; s < NUM_SLOTS; s++) en_or = en_or | en_q[s];
   end

   assign irq_drive_n_o = ~(|pend);

   // R8: the line is never pulled while every enable is clear
   p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_drive_n_o |-> (en_or != '0));

endmodule

// File: tb/hp_slot_irq_tb_top.sv
module hp_slot_irq_tb_top;

   localparam int NS = 4;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] bus_iso, pgood, pfault, mdet1, mdet0, cpres2, cpres1;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          irq_n;
   logic [6:0]    lvl [NS];

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   for (genvar s = 0; s < NS; s++) begin : g_drv
      assign bus_iso[s] = lvl[s][6];
      assign pgood[s]   = lvl[s][5];
      assign pfault[s]  = lvl[s][4];
      assign mdet1[s]   = lvl[s][3];
      assign mdet0[s]   = lvl[s][2];
      assign cpres2[s]  = lvl[s][1];
      assign cpres1[s]  = lvl[s][0];
   end

   hp_slot_irq #(.NUM_SLOTS(NS), .SYNC_STAGES(2)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_iso_i     (bus_iso),
      .pwr_good_i    (pgood),
      .pwr_fault_i   (pfault),
      .mdet1_i       (mdet1),
      .mdet0_i       (mdet0),
      .cpres2_i      (cpres2),
      .cpres1_i      (cpres1),
      .reg_addr_i    (addr),
      .reg_we_i      (we),
      .reg_wdata_i   (wdata),
      .reg_rdata_o   (rdata),
      .irq_drive_n_o (irq_n)
   );

   // {slot[21:20], source bit[19:17], enable[16:9], expected status[8:1], expected irq_n[0]}
   localparam logic [21:0] VEC [12] = '{
      {2'd0, 3'd6, 8'h40, 8'h40, 1'b0},   // R4 bus-iso rise, enabled
      {2'd0, 3'd6, 8'h00, 8'h40, 1'b1},   // R6 fall, disabled
      {2'd1, 3'd5, 8'h20, 8'h20, 1'b0},   // R4 power-good rise
      {2'd0, 3'd5, 8'h20, 8'h20, 1'b0},   // R4 power-good fall
      {2'd1, 3'd4, 8'h10, 8'h10, 1'b0},   // R5 fault asserts
      {2'd1, 3'd4, 8'h10, 8'h00, 1'b1},   // R5 fault releases: nothing
      {2'd2, 3'd3, 8'h08, 8'h08, 1'b0},   // R4 mdet1
      {2'd2, 3'd2, 8'h01, 8'h04, 1'b1},   // R6 mdet0, other bit enabled
      {2'd3, 3'd1, 8'h02, 8'h02, 1'b0},   // R4 cpres2
      {2'd2, 3'd0, 8'h01, 8'h01, 1'b0},   // R4 cpres1 fall
      {2'd3, 3'd0, 8'hFF, 8'h01, 1'b0},   // R3 bit7 write harmless
      {2'd3, 3'd4, 8'hEF, 8'h10, 1'b1}    // R6 fault with its enable clear
   };

   function automatic logic [AW-1:0] a_en(int s);
      return AW'(8 * s + 7);
   endfunction

   function automatic logic [AW-1:0] a_st(int s);
      return AW'(8 * s + 6);
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic reg_rd(logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [1:0] vs;
      logic [2:0] vb;

      lvl[0] = 7'b010_0000;   // power-good high through reset
      lvl[1] = 7'b000_0000;
      lvl[2] = 7'b000_0001;   // card-present 1 high through reset
      lvl[3] = 7'b000_0000;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);

      // R1 / R9: clean state, held levels create no events
      #1 check("R1 irq released", {7'b0, irq_n}, 8'h01);
      for (int s = 0; s < NS; s++) begin
         reg_rd(a_en(s), d); check("R1 enable reset", d, 8'h00);
         reg_rd(a_st(s), d); check("R9 no event from reset levels", d, 8'h00);
      end

      // R2: unmapped offsets
      reg_wr(5'h05, 8'hFF);
      reg_wr(5'h18, 8'hFF);
      reg_rd(5'h05, d); check("R2 unmapped read", d, 8'h00);
      reg_rd(5'h18, d); check("R2 unmapped read", d, 8'h00);
      reg_rd(a_en(0), d); check("R2 unmapped write no effect", d, 8'h00);
      reg_rd(a_en(3), d); check("R2 unmapped write no effect", d, 8'h00);

      // table walk
      for (int i = 0; i < 12; i++) begin
         vs = VEC[i][21:20];
         vb = VEC[i][19:17];
         reg_wr(a_en(int'(vs)), VEC[i][16:9]);
         @(negedge clk);
         lvl[vs][vb] = ~lvl[vs][vb];
         repeat (4) @(negedge clk);
         reg_rd(a_st(int'(vs)), d);
         check("R4 R5 R6 status", d, VEC[i][8:1]);
         check("R8 R6 irq", {7'b0, irq_n}, {7'b0, VEC[i][0]});
         reg_wr(a_st(int'(vs)), 8'hFF);
         #1 check("R8 irq released after clear", {7'b0, irq_n}, 8'h01);
         reg_rd(a_st(int'(vs)), d);
         check("R7 clear", d, 8'h00);
      end

      // R3: reserved bit
      reg_wr(a_en(1), 8'hFF);
      reg_rd(a_en(1), d); check("R3 reserved enable bit", d, 8'h7F);
      reg_wr(a_en(1), 8'h00);

      // R4: latency, change seen after the third edge
      @(negedge clk);
      addr = a_st(1);
      lvl[1][3] = ~lvl[1][3];
      @(negedge clk);
      @(negedge clk);
      #1 check("R4 not yet after two edges", rdata, 8'h00);
      @(negedge clk);
      #1 check("R4 set after third edge", rdata, 8'h08);

      // R7: writing zeros keeps the bit
      reg_wr(a_st(1), 8'hF7);
      reg_rd(a_st(1), d); check("R7 zero write keeps bit", d, 8'h08);

      // R7: event and clear in the same cycle
      @(negedge clk);
      lvl[1][3] = ~lvl[1][3];
      @(negedge clk);
      @(negedge clk);
      addr = a_st(1); wdata = 8'h08; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      reg_rd(a_st(1), d); check("R7 event wins over clear", d, 8'h08);
      reg_wr(a_st(1), 8'h08);
      reg_rd(a_st(1), d); check("R7 clear alone", d, 8'h00);

      // R8: release timing
      reg_wr(a_en(3), 8'h02);
      @(negedge clk);
      lvl[3][1] = ~lvl[3][1];
      repeat (4) @(negedge clk);
      #1 check("R8 irq driven", {7'b0, irq_n}, 8'h00);
      @(negedge clk);
      addr = a_st(3); wdata = 8'h02; we = 1'b1;
      #1 check("R8 held until clear edge", {7'b0, irq_n}, 8'h00);
      @(negedge clk);
      we = 1'b0;
      #1 check("R8 released next cycle", {7'b0, irq_n}, 8'h01);

      // R10: slot isolation
      @(negedge clk);
      lvl[3][2] = ~lvl[3][2];
      repeat (4) @(negedge clk);
      for (int s = 0; s < NS - 1; s++) begin
         reg_rd(a_st(s), d); check("R10 other slot untouched", d, 8'h00);
      end
      reg_rd(a_st(3), d); check("R10 own slot set", d, 8'h04);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule